// File: doc/BRIEF.md
# Supply Voltage Trip Detector Interrupt Logic

This block holds the digital side of a programmable supply-voltage detector. Software programs a 4-bit trip-point code and a sense direction, then sets the enable bit. The trip-point code goes out to an analog divider and comparator, which sit outside the block. The comparator answer comes back on `cmpAbove` (1 means the supply is above the trip point) and passes through a two-flop synchronizer.

Each time the block is enabled, a settling timer counts pulses of a fixed-rate `settleTick` input, so the interval does not depend on the system clock. Until the timer finishes, the reference-stable bit stays low and no event can be flagged. Once the reference is stable, a sticky event flag latches whenever the sensed condition holds. The direction bit picks the condition: 1 means supply above the trip point, 0 means supply below it. Software clears the flag through the register port. The flag is combined with a local enable and a global enable to form the interrupt request.

The register port has two addresses. Address 0 is the configuration register: bit 7 direction, bit 5 reference-stable (read only), bit 4 enable, bits 3:0 trip code, bit 6 reads 0. Address 1 is the flag register: bit 0 event flag, bit 1 local interrupt enable, bits 7:2 read 0. Reads are combinational on `regAddr`.

Top module: `volt_detect_irq`

## Requirements
- R1: After reset, both registers read 0, `tripCode` is 0 and `irqReq` is 0.
- R2: While the enable bit (address 0, bit 4) is 0, a write to address 0 loads the direction (bit 7) and the trip code (bits 3:0). Reads of address 0 return them in those positions, and `tripCode` follows the trip code.
- R3: While the enable bit is 1, a write to address 0 changes only the enable bit. The direction and trip code stay as they were, and `tripCode` stays constant.
- R4: After the enable bit is set, the reference-stable bit (address 0, bit 5) rises on the clock edge that samples the SETTLE_TICKS-th `settleTick` pulse seen while enabled. The number of clock cycles between pulses has no effect on this.
- R5: The write that clears the enable bit also clears the reference-stable bit and the settling count on the same edge. The next enable needs a full SETTLE_TICKS pulses again.
- R6: The event flag never sets while the reference-stable bit is 0. A comparator excursion that ends before settling completes leaves the flag at 0.
- R7: With direction 1, the flag sets when `cmpAbove` is 1. With direction 0, the flag sets when `cmpAbove` is 0.
- R8: A `cmpAbove` value held before clock edge N reaches the flag on edge N+2, through two synchronizer flops and the flag register.
- R9: The flag (address 1, bit 0) stays set until software writes 0 to it at address 1. If the condition still holds on the edge of that write, the set wins and the flag stays 1.
- R10: `irqReq` is 1 exactly when the event flag, the local enable (address 1, bit 1) and `glbIntEn` are all 1.
- R11: Writing 1 to the flag bit has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 configuration, 1 flag |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| settleTick | input | 1 | Fixed-rate pulse that advances the settling timer |
| cmpAbove | input | 1 | Asynchronous comparator result, 1 when supply is above the trip point |
| glbIntEn | input | 1 | Global interrupt enable |
| tripCode | output | 4 | Trip-point code sent to the analog divider |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench counts settling pulses with irregular idle gaps between them. A timer that counted clock cycles, or stopped one pulse early or late, would raise the reference-stable bit at the wrong pulse. It drives a comparator excursion during settling and checks the flag one edge before and on edge N+2, so a design that armed early or had a different number of synchronizer stages would show a wrong flag. It clears the flag while the condition still holds, where a design in which the clear wins would read 0. It also disables the block mid-run and checks that a stale settle count is not carried into the next enable. Last, it sweeps every direction and comparator level, every trip code, and all enable combinations of the interrupt gate.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
  localparam int DATA_W   = 8;
  localparam int TRIP_W   = 4;
  localparam int EN_POS   = 4;
  localparam int RDY_POS  = 5;
  localparam int DIR_POS  = 7;
  localparam int FLAG_POS = 0;
  localparam int IE_POS   = 1;
  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_FLAG = 1'b1;

  typedef struct packed {
    logic loadCfg;
    logic clrFlag;
    logic writeIe;
    logic ieVal;
    logic armed;
  } vdet_strobe_t;
endpackage

// File: rtl/vdet_ctrl.sv
module vdet_ctrl
  import vdet_pkg::*;
#(
  parameter int SETTLE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              settleTick,
  output logic              enBit,
  output logic              refStable,
  output vdet_strobe_t      stb
);
  localparam int CNT_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

  logic             enQ, rdyQ, wrCfg, enNext;
  logic [CNT_W-1:0] cntQ;

  assign wrCfg  = regWe && (regAddr == ADDR_CFG);
  assign enNext = wrCfg ? regWdata[EN_POS] : enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= 1'b0;
      rdyQ <= 1'b0;
      cntQ <= '0;
    end else begin
      enQ <= enNext;
      if (!enNext) begin
        rdyQ <= 1'b0;
        cntQ <= '0;
      end else if (enQ && !rdyQ && settleTick) begin
        if (cntQ == LAST) rdyQ <= 1'b1;
        else              cntQ <= cntQ + 1'b1;
      end
    end
  end

  always_comb begin
    stb.loadCfg = wrCfg && !enQ;
    stb.clrFlag = regWe && (regAddr == ADDR_FLAG) && !regWdata[FLAG_POS];
    stb.writeIe = regWe && (regAddr == ADDR_FLAG);
    stb.ieVal   = regWdata[IE_POS];
    stb.armed   = enQ && rdyQ;
  end

  assign enBit     = enQ;
  assign refStable = rdyQ;
endmodule

// File: rtl/vdet_dpath.sv
module vdet_dpath
  import vdet_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vdet_strobe_t      stb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regAddr,
  input  logic              enBit,
  input  logic              refStable,
  input  logic              cmpAbove,
  input  logic              glbIntEn,
  output logic [DATA_W-1:0] regRdata,
  output logic [TRIP_W-1:0] tripCode,
  output logic              evtFlag,
  output logic              irqReq
);
  logic [TRIP_W-1:0] tripQ;
  logic              dirQ, syncA, syncB, flagQ, ieQ, condHit, setEvt;

  assign condHit = dirQ ? syncB : !syncB;
  assign setEvt  = stb.armed && condHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripQ <= '0;
      dirQ  <= 1'b0;
      syncA <= 1'b0;
      syncB <= 1'b0;
      flagQ <= 1'b0;
      ieQ   <= 1'b0;
    end else begin
      syncA <= cmpAbove;
      syncB <= syncA;
      if (stb.loadCfg) begin
        tripQ <= regWdata[TRIP_W-1:0];
        dirQ  <= regWdata[DIR_POS];
      end
      if (stb.writeIe) ieQ <= stb.ieVal;
      flagQ <= setEvt || (flagQ && !stb.clrFlag);
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CFG) begin
      regRdata[TRIP_W-1:0] = tripQ;
      regRdata[EN_POS]     = enBit;
      regRdata[RDY_POS]    = refStable;
      regRdata[DIR_POS]    = dirQ;
    end else begin
      regRdata[FLAG_POS] = flagQ;
      regRdata[IE_POS]   = ieQ;
    end
  end

  assign tripCode = tripQ;
  assign evtFlag  = flagQ;
  assign irqReq   = flagQ && ieQ && glbIntEn;
endmodule

// File: rtl/volt_detect_irq.sv
module volt_detect_irq
  import vdet_pkg::*;
#(
  parameter int SETTLE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              settleTick,
  input  logic              cmpAbove,
  input  logic              glbIntEn,
  output logic [TRIP_W-1:0] tripCode,
  output logic              irqReq
);
  vdet_strobe_t stb;
  logic         enBit, refStable, evtFlag;

  vdet_ctrl #(.SETTLE_TICKS(SETTLE_TICKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .settleTick(settleTick),
    .enBit(enBit), .refStable(refStable), .stb(stb)
  );

  vdet_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata),
    .regAddr(regAddr), .enBit(enBit), .refStable(refStable),
    .cmpAbove(cmpAbove), .glbIntEn(glbIntEn), .regRdata(regRdata),
    .tripCode(tripCode), .evtFlag(evtFlag), .irqReq(irqReq)
  );
endmodule

// File: rtl/vdet_checker.sv
module vdet_checker
  import vdet_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              enBit,
  input logic              refStable,
  input logic              evtFlag,
  input logic              clrFlag,
  input logic              irqReq,
  input logic [TRIP_W-1:0] tripCode
);
  // R6
  no_early_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtFlag) |-> $past(refStable));

  // R5
  disable_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enBit) |-> !refStable);

  // R4
  ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    refStable |-> enBit);

  // R3
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && $past(enBit)) |-> $stable(tripCode));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(evtFlag && !clrFlag) |-> evtFlag);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> evtFlag);
endmodule

bind volt_detect_irq vdet_checker i_vdet_checker (
  .clk(clk), .rstN(rstN), .enBit(enBit), .refStable(refStable),
  .evtFlag(evtFlag), .clrFlag(stb.clrFlag), .irqReq(irqReq),
  .tripCode(tripCode)
);

// File: tb/test_volt_detect_irq.sv
`timescale 1ns/1ps
module test_volt_detect_irq;
  localparam int NT = 4;
  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, regAddr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic settleTick = 1'b0, cmpAbove = 1'b0, glbIntEn = 1'b0;
  logic [3:0] tripCode;
  logic irqReq;
  int nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  volt_detect_irq #(.SETTLE_TICKS(NT)) i_volt_detect_irq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .settleTick(settleTick),
    .cmpAbove(cmpAbove), .glbIntEn(glbIntEn), .tripCode(tripCode),
    .irqReq(irqReq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic tick();
    @(negedge clk); settleTick = 1'b1;
    @(negedge clk); settleTick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] cfgWord(logic d, logic e, logic r, logic [3:0] t);
    return {d, 1'b0, r, e, t};
  endfunction

  task automatic armUp(logic d, logic [3:0] t);
    wr(1'b0, cfgWord(d, 1'b0, 1'b0, t));
    wr(1'b0, cfgWord(d, 1'b1, 1'b0, t));
    for (int i = 0; i < NT; i++) tick();
  endtask

  initial begin
    #200000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3);
    // R1 reset state
    rd(1'b0, d); chk("R1 cfg", d, 8'h00);
    rd(1'b1, d); chk("R1 flag", d, 8'h00);
    chk("R1 trip", {4'h0, tripCode}, 8'h00);
    chk("R1 irq", {7'h0, irqReq}, 8'h00);
    rstN = 1'b1;
    idle(2);

    // R2 sweep of trip codes and directions while disabled
    for (int t = 0; t < 16; t++) begin
      for (int dd = 0; dd < 2; dd++) begin
        wr(1'b0, cfgWord(dd[0], 1'b0, 1'b0, t[3:0]));
        rd(1'b0, d); chk("R2 readback", d, cfgWord(dd[0], 1'b0, 1'b0, t[3:0]));
        chk("R2 tripCode", {4'h0, tripCode}, {4'h0, t[3:0]});
      end
    end

    // R3 writes while enabled touch only the enable bit
    wr(1'b0, cfgWord(1'b1, 1'b0, 1'b0, 4'd5));
    wr(1'b0, cfgWord(1'b1, 1'b1, 1'b0, 4'd5));
    wr(1'b0, cfgWord(1'b0, 1'b1, 1'b0, 4'd9));
    rd(1'b0, d); chk("R3 cfg held", d, cfgWord(1'b1, 1'b1, 1'b0, 4'd5));
    chk("R3 tripCode held", {4'h0, tripCode}, 8'd5);

    // R4 settling counted in ticks with irregular gaps; R6 excursion ignored
    for (int k = 1; k <= NT; k++) begin
      idle(k * 3);
      if (k == 2) begin
        cmpAbove = 1'b1; idle(5); cmpAbove = 1'b0; idle(4);
      end
      rd(1'b0, d); chk("R4 before tick", {7'h0, d[5]}, 8'h00);
      tick();
      rd(1'b0, d); chk("R4 after tick", {7'h0, d[5]}, {7'h0, (k >= NT)});
    end
    rd(1'b1, d); chk("R6 excursion dropped", {7'h0, d[0]}, 8'h00);

    // R8 synchronizer latency
    cmpAbove = 1'b1;
    idle(2);
    rd(1'b1, d); chk("R8 not yet", {7'h0, d[0]}, 8'h00);
    idle(1);
    rd(1'b1, d); chk("R8 on edge N+2", {7'h0, d[0]}, 8'h01);

    // R10 interrupt gate sweep, R11 writing 1 leaves flag alone
    for (int ie = 0; ie < 2; ie++) begin
      for (int g = 0; g < 2; g++) begin
        wr(1'b1, {6'h0, ie[0], 1'b1});
        glbIntEn = g[0];
        #0.5;
        chk("R10 irq", {7'h0, irqReq}, {7'h0, ie[0] & g[0]});
        rd(1'b1, d); chk("R11 flag kept", {7'h0, d[0]}, 8'h01);
      end
    end

    // R9 set wins over clear, then stickiness
    wr(1'b1, 8'h02);
    rd(1'b1, d); chk("R9 set wins", d, 8'h03);
    cmpAbove = 1'b0;
    idle(4);
    rd(1'b1, d); chk("R9 sticky", d, 8'h03);
    wr(1'b1, 8'h02);
    rd(1'b1, d); chk("R9 cleared", d, 8'h02);
    chk("R10 irq low", {7'h0, irqReq}, 8'h00);
    wr(1'b1, 8'h03);
    rd(1'b1, d); chk("R11 write one", d, 8'h02);

    // R5 disable clears settling immediately, re-enable restarts count
    tick();
    wr(1'b0, cfgWord(1'b1, 1'b0, 1'b0, 4'd5));
    rd(1'b0, d); chk("R5 disabled", d, cfgWord(1'b1, 1'b0, 1'b0, 4'd5));
    wr(1'b0, cfgWord(1'b1, 1'b1, 1'b0, 4'd5));
    for (int i = 0; i < NT - 1; i++) tick();
    rd(1'b0, d); chk("R5 restart short", {7'h0, d[5]}, 8'h00);
    tick();
    rd(1'b0, d); chk("R5 restart full", {7'h0, d[5]}, 8'h01);

    // R7 direction and comparator sweep
    for (int dd = 0; dd < 2; dd++) begin
      for (int c = 0; c < 2; c++) begin
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h02);
        cmpAbove = c[0];
        armUp(dd[0], 4'd3);
        idle(4);
        rd(1'b1, d);
        chk("R7 direction", {7'h0, d[0]}, {7'h0, dd[0] ? c[0] : !c[0]});
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule